// File: doc/BRIEF.md
# Serial-to-Parallel Deserializer with One-Bit Slip

This block turns a serial bit stream into 16-bit words. All of its state runs on the serial clock. An internal divide-by-16 counter frames the stream into word periods. From that counter the block derives a parallel clock output with equal high and low phases. A one-cycle word-valid strobe marks each cycle in which a new word lands in the output register. Bit order is fixed: the first bit received in a word period appears on bit 0 of the word, and the last one on bit 15.

A downstream framer that finds the word boundary in the wrong place raises the synchronization input. The block counts how long that input stays high. A pulse that lasts at least four serial clocks is taken as a request to slip. The divide counter then stalls for one serial clock at the start of a word period. That period lasts 17 serial clocks, and its first bit is shifted out without being delivered, so every later word boundary moves by one bit. Pulses shorter than four clocks are ignored. A pulse that stays high for a long time still produces only one slip.

Top module: `deser16_slip`

## Requirements
- R1: While `rst` is high at a rising clock edge, `par_word`, `par_clk` and `word_vld` are all 0 after that edge. After `rst` falls, the first `word_vld` comes at the end of the 16th serial bit, so the first word holds exactly the first 16 bits sampled after reset.
- R2: `ser_in` is sampled on every rising clock edge. Each delivered word holds the 16 most recently sampled bits, with the oldest on bit 0 and the newest on bit 15.
- R3: In normal operation `word_vld` is high for exactly one clock, and successive strobes are 16 clocks apart.
- R4: `par_clk` is high for exactly 8 clocks of every word period. It falls in the same cycle as the rising edge of `word_vld`. It is low for the rest of the period: 8 clocks, or 9 in a lengthened period.
- R5: `par_word` changes only in cycles where `word_vld` is high.
- R6: A high pulse on `sync_in` that lasts 1, 2 or 3 clocks has no effect: every strobe spacing stays 16.
- R7: A high pulse on `sync_in` that lasts 4 or more clocks causes exactly one word period of 17 clocks. The bit sampled first in that period is never delivered, and words keep holding the 16 most recent bits as in R2.
- R8: A pulse held high for many word periods still produces only one slip. `sync_in` must go low before another slip can be requested. A request accepted while a slip is still pending is merged into that slip.
- R9: The lengthened word period begins no later than 32 clocks after the first clock at which `sync_in` is sampled high.
- R10: Reset clears the sync-width count, so high samples taken before reset do not add to the count after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock; every register uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data bit |
| sync_in | input | 1 | Slip request, level qualified by its width |
| par_word | output | 16 | Deserialized word, bit 0 received first |
| par_clk | output | 1 | Serial clock divided by 16 |
| word_vld | output | 1 | One-clock strobe when `par_word` updates |

## Verification
A fault in the divide counter shows up within one word period: the strobe spacing becomes something other than 16 or 17 clocks, or the high phase of `par_clk` is no longer 8 clocks wide. A fault in the shift path or the bit order shows in the very next delivered word, because every word is compared bit by bit against the last 16 bits driven. A fault in the sync qualifier shows within two word periods of a pulse: a slip is missing, comes late, or is doubled, or a pulse that was too short produces a 17-clock period.

// File: rtl/deser_pkg.sv
package deser_pkg;

    localparam int unsigned WORD_W_DEF = 16;
    localparam int unsigned MIN_HI_DEF = 4;

    // qualifier phase of the sync input
    typedef enum logic [1:0] {
        Q_LOW   = 2'd0,
        Q_RUN   = 2'd1,
        Q_SPENT = 2'd2
    } qual_state_t;

    // per-cycle framing controls from the divider
    typedef struct packed {
        logic hold;   // counter stalls, one bit is discarded
        logic load;   // last bit of the word arrives this cycle
    } div_ctl_t;

    function automatic int unsigned cnt_width(input int unsigned w);
        return (w <= 2) ? 1 : $clog2(w);
    endfunction

endpackage

// File: rtl/deser_shift.sv
module deser_shift #(
    parameter int unsigned WORD_W = deser_pkg::WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    output logic [WORD_W-1:0] assembled
);
    logic [WORD_W-1:0] sr_q;

    // newest bit enters at the top, oldest drifts toward bit 0
    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else begin
            sr_q <= {ser_in, sr_q[WORD_W-1:1]};
        end
    end

    // word including the bit sampled at this edge
    always_comb begin
        assembled = {ser_in, sr_q[WORD_W-1:1]};
    end
endmodule

// File: rtl/deser_divider.sv
module deser_divider
    import deser_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     slip_req,
    output div_ctl_t ctl,
    output logic     par_clk
);
    localparam int unsigned CNT_W = cnt_width(WORD_W);
    localparam int unsigned LAST  = WORD_W - 1;
    localparam int unsigned HALF  = WORD_W / 2;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             pclk_q;

    always_comb begin
        ctl.hold = slip_req && (cnt_q == '0);
        ctl.load = (cnt_q == CNT_W'(LAST)) && !ctl.hold;
        if (ctl.hold) begin
            cnt_nxt = cnt_q;
        end else if (cnt_q == CNT_W'(LAST)) begin
            cnt_nxt = '0;
        end else begin
            cnt_nxt = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pclk_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_nxt;
            pclk_q <= (cnt_nxt >= CNT_W'(HALF));
        end
    end

    assign par_clk = pclk_q;
endmodule

// File: rtl/deser_sync_qual.sv
module deser_sync_qual
    import deser_pkg::*;
#(
    parameter int unsigned MIN_HI = MIN_HI_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    input  logic taken,
    output logic slip_pend
);
    localparam int unsigned RUN_W = $clog2(MIN_HI + 1);

    qual_state_t      st_q;
    logic [RUN_W-1:0] run_q;
    logic             pend_q;
    logic             accept;

    always_comb begin
        accept = sync_in && (st_q != Q_SPENT) && (run_q == RUN_W'(MIN_HI - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= Q_LOW;
            run_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (!sync_in) begin
                st_q  <= Q_LOW;
                run_q <= '0;
            end else if (accept) begin
                st_q  <= Q_SPENT;
            end else if (st_q != Q_SPENT) begin
                st_q  <= Q_RUN;
                run_q <= run_q + 1'b1;
            end

            if (accept) begin
                pend_q <= 1'b1;
            end else if (taken) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign slip_pend = pend_q;
endmodule

// File: rtl/deser_outreg.sv
module deser_outreg #(
    parameter int unsigned WORD_W = deser_pkg::WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_out,
    output logic              vld
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_out <= '0;
            vld      <= 1'b0;
        end else begin
            vld <= load;
            if (load) begin
                word_out <= word_in;
            end
        end
    end
endmodule

// File: rtl/deser16_slip.sv
module deser16_slip
    import deser_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF,
    parameter int unsigned MIN_HI = MIN_HI_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic              sync_in,
    output logic [WORD_W-1:0] par_word,
    output logic              par_clk,
    output logic              word_vld
);
    logic [WORD_W-1:0] assembled;
    logic              slip_pend;
    div_ctl_t          ctl;
    logic              slip_hold;

    deser_shift #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .ser_in    (ser_in),
        .assembled (assembled)
    );

    deser_sync_qual #(.MIN_HI(MIN_HI)) u_qual (
        .clk       (clk),
        .rst       (rst),
        .sync_in   (sync_in),
        .taken     (slip_hold),
        .slip_pend (slip_pend)
    );

    deser_divider #(.WORD_W(WORD_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .slip_req (slip_pend),
        .ctl      (ctl),
        .par_clk  (par_clk)
    );

    assign slip_hold = ctl.hold;

    deser_outreg #(.WORD_W(WORD_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl.load),
        .word_in  (assembled),
        .word_out (par_word),
        .vld      (word_vld)
    );
endmodule

// File: rtl/deser16_slip_chk.sv
module deser16_slip_chk #(
    parameter int unsigned WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] par_word,
    input logic              par_clk,
    input logic              word_vld,
    input logic              hold
);
    localparam int unsigned GAP_W = $clog2(WORD_W + 2);
    localparam int unsigned HALF  = WORD_W / 2;

    logic [GAP_W-1:0] since_vld;
    logic [GAP_W-1:0] hi_run;
    logic             seen_vld;
    logic             rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            since_vld <= '0;
            hi_run    <= '0;
            seen_vld  <= 1'b0;
        end else begin
            if (word_vld) begin
                since_vld <= '0;
                seen_vld  <= 1'b1;
            end else if (since_vld != '1) begin
                since_vld <= since_vld + 1'b1;
            end
            if (!par_clk) begin
                hi_run <= '0;
            end else if (hi_run != '1) begin
                hi_run <= hi_run + 1'b1;
            end
        end
    end

    // R3, R7: strobe spacing is 16, or 17 in a slipped period
    p_vld_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (word_vld && seen_vld) |-> (since_vld == GAP_W'(WORD_W - 1) || since_vld == GAP_W'(WORD_W)));

    // R4: high phase never longer than half a word
    p_pclk_high_r4: assert property (@(posedge clk) disable iff (rst)
        par_clk |-> (hi_run < GAP_W'(HALF)));

    // R4: strobe coincides with the falling edge of the parallel clock
    p_pclk_fall_r4: assert property (@(posedge clk) disable iff (rst)
        word_vld |-> $fell(par_clk));

    // R5: the word holds between strobes
    p_word_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!word_vld && !rst_d) |-> $stable(par_word));

    // R8: a slip stalls the framing for exactly one clock
    p_hold_single_r8: assert property (@(posedge clk) disable iff (rst)
        hold |=> !hold);
endmodule

bind deser16_slip deser16_slip_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .par_word (par_word),
    .par_clk  (par_clk),
    .word_vld (word_vld),
    .hold     (slip_hold)
);

// File: tb/tb_deser16_slip.sv
module tb_deser16_slip;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_in = 1'b0;
    logic         sync_in = 1'b0;
    logic [W-1:0] par_word;
    logic         par_clk;
    logic         word_vld;

    deser16_slip dut (
        .clk      (clk),
        .rst      (rst),
        .ser_in   (ser_in),
        .sync_in  (sync_in),
        .par_word (par_word),
        .par_clk  (par_clk),
        .word_vld (word_vld)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int           checks = 0;
    int           fails = 0;
    logic         bits [256];
    int           n = 0;
    int           last_vld = -1;
    int           hi_cnt = 0;
    int           slips = 0;
    int           slip_at = 0;
    int           rise_n = 0;
    logic         prev_sync = 1'b0;
    logic [W-1:0] prev_word = '0;
    logic [15:0]  lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic next_bit(input int kind);
        logic b;
        case (kind)
            0: b = 1'b1;
            1: b = n[0];
            2: b = 1'b0;
            default: begin
                b    = lfsr[0];
                lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
            end
        endcase
        return b;
    endfunction

    // sample outputs, then drive one serial bit and the sync level
    task automatic step(input logic s, input logic y);
        logic [W-1:0] exp_w;
        int           gap;
        @(negedge clk);
        if (word_vld) begin
            for (int i = 0; i < W; i++) exp_w[i] = bits[(n - W + i) & 255];
            chk(par_word == exp_w, "R2", "word bits", par_word, exp_w);
            if (last_vld < 0) begin
                chk(n == W, "R1", "first word bit count", n, W);
            end else begin
                gap = n - last_vld;
                if (gap == W + 1) begin
                    slips++;
                    slip_at = n;
                end else begin
                    chk(gap == W, "R3", "strobe spacing", gap, W);
                end
            end
            chk(!par_clk && hi_cnt == W/2, "R4", "pclk high count at fall", hi_cnt, W/2);
            last_vld = n;
            hi_cnt   = 0;
        end else begin
            chk(par_word == prev_word, "R5", "word changed without strobe", par_word, prev_word);
            if (par_clk) hi_cnt++;
        end
        prev_word = par_word;
        if (y && !prev_sync) rise_n = n;
        prev_sync = y;
        ser_in  = s;
        sync_in = y;
        bits[n & 255] = s;
        n++;
    endtask

    task automatic run_bits(input int count, input int kind, input logic y);
        for (int i = 0; i < count; i++) step(next_bit(kind), y);
    endtask

    task automatic do_reset(input logic y);
        @(negedge clk);
        rst = 1'b1;
        sync_in = y;
        ser_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(par_word == '0 && !par_clk && !word_vld, "R1", "outputs in reset",
            {par_word, par_clk, word_vld}, 0);
        rst = 1'b0;
        ser_in = 1'b0;
        sync_in = y;
        bits[0] = 1'b0;
        n = 1;
        last_vld = -1;
        hi_cnt = 0;
        prev_word = '0;
        prev_sync = y;
        slips = 0;
    endtask

    task automatic t_reset_first();
        do_reset(1'b0);
        run_bits(15, 3, 1'b0);
        chk(last_vld < 0, "R1", "no strobe before 16 bits", last_vld, -1);
        run_bits(49, 3, 1'b0);
        chk(last_vld >= 0, "R1", "first word delivered", last_vld, W);
        chk(slips == 0, "R3", "no slip without sync", slips, 0);
    endtask

    task automatic t_patterns();
        slips = 0;
        run_bits(64, 0, 1'b0);
        run_bits(64, 1, 1'b0);
        run_bits(64, 2, 1'b0);
        run_bits(96, 3, 1'b0);
        chk(slips == 0, "R3", "patterns keep 16 spacing", slips, 0);
    endtask

    task automatic t_short_pulses();
        for (int w = 1; w <= 3; w++) begin
            slips = 0;
            run_bits(w, 3, 1'b1);
            run_bits(45, 3, 1'b0);
            chk(slips == 0, "R6", "short sync pulse ignored", slips, 0);
        end
    endtask

    task automatic t_accept();
        for (int ph = 0; ph < 4; ph++) begin
            run_bits(ph * 5 + 1, 3, 1'b0);
            slips = 0;
            run_bits(4, 3, 1'b1);
            run_bits(60, 3, 1'b0);
            chk(slips == 1, "R7", "one slip per 4-clock pulse", slips, 1);
            chk((slip_at - W - 1 - rise_n) <= 32 && (slip_at - W - 1 - rise_n) >= 3,
                "R9", "slip latency", slip_at - W - 1 - rise_n, 32);
        end
    endtask

    task automatic t_long_pulse();
        slips = 0;
        run_bits(70, 3, 1'b1);
        run_bits(50, 3, 1'b0);
        chk(slips == 1, "R8", "long pulse single slip", slips, 1);
        slips = 0;
        run_bits(6, 3, 1'b1);
        run_bits(50, 3, 1'b0);
        chk(slips == 1, "R8", "new slip after sync low", slips, 1);
    endtask

    task automatic t_reset_clears();
        run_bits(3, 3, 1'b1);
        do_reset(1'b1);
        run_bits(2, 3, 1'b1);
        run_bits(60, 3, 1'b0);
        chk(slips == 0, "R10", "pre-reset highs discarded", slips, 0);
        chk(last_vld >= 0, "R1", "words after mid-run reset", last_vld, W);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", n, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset_first();
        t_patterns();
        t_short_pulses();
        t_accept();
        t_long_pulse();
        t_reset_clears();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule